// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns a 32-bit program counter and, on every enabled clock edge, replaces it with the address of the next instruction. It decodes the instruction word that was fetched at the current PC. It then picks one of four targets: the plain sequential successor, a PC-relative target for the two conditional compares, a region-local absolute target for the jumps, or a full 32-bit register value.

Register reads, instruction memory and the rest of the datapath are outside the block. The two source-register values arrive on input ports together with the instruction word. The block drives a taken flag for redirected flow. For a jump-and-link it also drives a write strobe and the return address, so that an outside register file can store the return address.

There are no delay slots and no pipelining. The PC register reloads from the computed target in the same edge that consumes the instruction.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC with 0x00400000, whether or not the enable input is high.
- R2: Any opcode (bits 31..26) other than 0, 2, 3, 4 and 5 advances the PC to PC+4 and leaves taken low. Opcode 0 with any function value (bits 5..0) other than 0x08 does the same.
- R3: Opcode 4 with equal operand values branches to (PC+4) + sign-extended bits 15..0 times 4 and raises taken. The largest forward offset is 0x7FFF.
- R4: Opcode 4 with unequal operand values falls through to PC+4 with taken low.
- R5: Opcode 5 branches to the same PC-relative target when the operand values differ, and falls through with taken low when they match.
- R6: Branch offsets are two's complement, so bit 15 set moves the PC backward. Offset 0x8000 reaches (PC+4) - 0x20000.
- R7: Opcode 2 jumps to PC[31:28], then bits 25..0 of the word, then two zero bits, and raises taken.
- R8: Opcode 3 jumps like opcode 2. While the enable input is high it also raises the link strobe with the link address PC+4. The link strobe stays low for every other opcode.
- R9: Opcode 0 with function 0x08 loads the whole rs operand value into the PC and raises taken, even when that value leaves the current 256 MB region.
- R10: While the enable input is low, the PC keeps its value and the link strobe stays low.
- R11: All PC arithmetic wraps modulo 2^32, so that PC 0xFFFFFFFC advances sequentially to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | PC update enable |
| instr | input | 32 | Instruction word fetched at the current PC |
| rs_val | input | 32 | Value of the register named by bits 25..21 |
| rt_val | input | 32 | Value of the register named by bits 20..16 |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | Return address PC+4 for jump-and-link |
| link_we | output | 1 | Link write strobe |
| taken | output | 1 | Current instruction redirects flow |

## Verification
All decode and target selection is combinational, and the only state is the PC register. A wrong decode or a wrong target therefore appears on the taken and link outputs in the same cycle the word is presented. It appears on the pc port exactly one enabled edge later. A wrong PC value then makes every later sequential or PC-relative target wrong by the same offset. For this reason the bench compares pc after every edge, instead of only at the end of a sequence. Region-preserving jumps are run after a register jump has moved the PC into a nonzero upper region, so that a dropped upper-bit splice cannot hide behind an all-zero region.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN     = 32;
  localparam int OPC_W    = 6;
  localparam int FUNCT_W  = 6;
  localparam int IMM_W    = 16;
  localparam int TGT_W    = 26;
  localparam int REGION_W = XLEN - TGT_W - 2;
  localparam int INSN_BYTES = 4;

  localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0]   OPC_JMP     = 6'd2;
  localparam logic [OPC_W-1:0]   OPC_JAL     = 6'd3;
  localparam logic [OPC_W-1:0]   OPC_BEQ     = 6'd4;
  localparam logic [OPC_W-1:0]   OPC_BNE     = 6'd5;
  localparam logic [FUNCT_W-1:0] FN_JREG     = 6'h08;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BEQ,
    FLOW_BNE,
    FLOW_JMP,
    FLOW_JAL,
    FLOW_JREG
  } flow_e;

  // Address of the following instruction, wrapping modulo 2^XLEN.
  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] cur);
    return cur + XLEN'(INSN_BYTES);
  endfunction

  // PC-relative target: word offset, sign-extended, scaled by four.
  function automatic logic [XLEN-1:0] f_rel(input logic [XLEN-1:0] base,
                                            input logic [IMM_W-1:0] off);
    logic [XLEN-1:0] disp;
    disp = {{(XLEN-IMM_W-2){off[IMM_W-1]}}, off, 2'b00};
    return base + disp;
  endfunction

  // Region-local absolute target: keep the top bits of the PC.
  function automatic logic [XLEN-1:0] f_region(input logic [XLEN-1:0] cur,
                                               input logic [TGT_W-1:0] tgt);
    return {cur[XLEN-1 -: REGION_W], tgt, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNCT_W-1:0] funct,
  output flow_e              flow
);
  always_comb begin
    unique case (opcode)
      OPC_BEQ:     flow = FLOW_BEQ;
      OPC_BNE:     flow = FLOW_BNE;
      OPC_JMP:     flow = FLOW_JMP;
      OPC_JAL:     flow = FLOW_JAL;
      OPC_SPECIAL: flow = (funct == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
      default:     flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  flow_e            flow,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [TGT_W-1:0] tgt_field,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  next_pc,
  output logic             redirect
);
  logic            operands_eq;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] abs_pc;

  assign operands_eq = (rs_val == rt_val);
  assign seq_pc      = f_seq(cur_pc);
  assign rel_pc      = f_rel(seq_pc, tgt_field[IMM_W-1:0]);
  assign abs_pc      = f_region(cur_pc, tgt_field);

  always_comb begin
    redirect = 1'b0;
    next_pc  = seq_pc;
    unique case (flow)
      FLOW_BEQ: begin
        redirect = operands_eq;
        if (operands_eq) next_pc = rel_pc;
      end
      FLOW_BNE: begin
        redirect = !operands_eq;
        if (!operands_eq) next_pc = rel_pc;
      end
      FLOW_JMP, FLOW_JAL: begin
        redirect = 1'b1;
        next_pc  = abs_pc;
      end
      FLOW_JREG: begin
        redirect = 1'b1;
        next_pc  = rs_val;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)     pc <= RESET_PC;
    else if (en) pc <= next_pc;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] link_addr,
  output logic        link_we,
  output logic        taken
);
  flow_e            flow;
  logic [XLEN-1:0]  next_pc;
  logic [XLEN-1:0]  seq_pc;

  npc_decode u_decode (
    .opcode (instr[XLEN-1 -: OPC_W]),
    .funct  (instr[FUNCT_W-1:0]),
    .flow   (flow)
  );

  npc_target u_target (
    .flow      (flow),
    .cur_pc    (pc),
    .tgt_field (instr[TGT_W-1:0]),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .seq_pc    (seq_pc),
    .next_pc   (next_pc),
    .redirect  (taken)
  );

  npc_pc_reg #(.RESET_PC(RESET_PC)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .next_pc (next_pc),
    .pc      (pc)
  );

  assign link_addr = seq_pc;
  assign link_we   = en && (flow == FLOW_JAL);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic        taken
);
  logic [5:0] opc;
  assign opc = instr[31:26];

  p_reset_value_r1: assert property (@(posedge clk) rst |=> (pc == RESET_PC))
    else $error("reset value");

  p_follow_next_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> (pc == $past(next_pc)))
    else $error("pc does not follow next_pc");

  p_plain_opcode_r2: assert property (@(posedge clk) disable iff (rst)
    (opc > 6'd5 || opc == 6'd1) |-> !taken)
    else $error("taken on plain opcode");

  p_region_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (en && opc == 6'd2) |=> (pc[31:28] == $past(pc[31:28]) && pc[1:0] == 2'b00))
    else $error("jump left its region");

  p_link_only_jal_r8: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (opc == 6'd3 && taken))
    else $error("link strobe without jal");

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc))
    else $error("pc moved while disabled");

  p_no_link_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !en |-> !link_we)
    else $error("link strobe while disabled");
endmodule

bind npc_unit npc_unit_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .instr   (instr),
  .pc      (pc),
  .next_pc (next_pc),
  .link_we (link_we),
  .taken   (taken)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b1;
  logic [31:0] instr  = 32'h0;
  logic [31:0] rs_val = 32'h0;
  logic [31:0] rt_val = 32'h0;
  logic [31:0] pc;
  logic [31:0] link_addr;
  logic        link_we;
  logic        taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst(rst), .en(en), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc),
    .link_addr(link_addr), .link_we(link_we), .taken(taken)
  );

  // Example loop: instr, rs value, rt value, expected next PC, expected taken
  localparam int NV = 8;
  localparam logic [31:0] V_INS [NV] = '{32'h0000_1025, 32'h0005_402A, 32'h1100_0003,
    32'h0044_1020, 32'h20A5_FFFF, 32'h0810_0001, 32'h0005_402A, 32'h1100_0003};
  localparam logic [31:0] V_RS [NV] = '{0, 0, 1, 0, 0, 0, 0, 0};
  localparam logic [31:0] V_RT [NV] = '{0, 5, 0, 0, 0, 0, 5, 0};
  localparam logic [31:0] V_NPC [NV] = '{32'h0040_0004, 32'h0040_0008, 32'h0040_000C,
    32'h0040_0010, 32'h0040_0014, 32'h0040_0004, 32'h0040_0008, 32'h0040_0018};
  localparam logic V_TK [NV] = '{0, 0, 0, 0, 0, 1, 0, 1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Present a word at the negedge, check combinational outputs, then the PC after the edge.
  task automatic step(input string tag, input logic [31:0] w, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] exp_pc, input logic exp_tk);
    instr = w; rs_val = a; rt_val = b;
    #1;
    chk({tag, " taken"}, {31'b0, taken}, {31'b0, exp_tk});
    @(negedge clk);
    chk({tag, " pc"}, pc, exp_pc);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset pc", pc, 32'h0040_0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      step($sformatf("R2/R3/R4/R7 vec%0d", i), V_INS[i], V_RS[i], V_RT[i], V_NPC[i], V_TK[i]);

    // R5 R6 backward not-equal branch, then not-taken equal case
    step("R5 R6 bne back", 32'h1400_FFFE, 32'd1, 32'd2, 32'h0040_0014, 1'b1);
    chk("R8 no link on bne", {31'b0, link_we}, 32'd0);
    step("R5 bne equal", 32'h1400_FFFE, 32'd3, 32'd3, 32'h0040_0018, 1'b0);

    // R8 jump-and-link
    instr = 32'h0C00_0010; #1;
    chk("R8 link_we", {31'b0, link_we}, 32'd1);
    chk("R8 link_addr", link_addr, 32'h0040_001C);
    @(negedge clk);
    chk("R8 jal pc", pc, 32'h0000_0040);

    // R9 register jump into a nonzero region, then R7 region kept
    step("R9 jr", 32'h0000_0008, 32'h7000_0000, 32'd0, 32'h7000_0000, 1'b1);
    step("R7 j region", 32'h0800_0003, 32'd0, 32'd0, 32'h7000_000C, 1'b1);
    step("R9 other funct", 32'h0000_0020, 32'h1234_5678, 32'd0, 32'h7000_0010, 1'b0);

    // R10 disabled: PC held, no link
    en = 1'b0;
    instr = 32'h0C00_0000; #1;
    chk("R10 link_we idle", {31'b0, link_we}, 32'd0);
    @(negedge clk);
    chk("R10 hold", pc, 32'h7000_0010);
    en = 1'b1;

    // R11 wrap
    step("R9 jr top", 32'h0000_0008, 32'hFFFF_FFFC, 32'd0, 32'hFFFF_FFFC, 1'b1);
    step("R11 wrap", 32'h0000_0000, 32'd0, 32'd0, 32'h0000_0000, 1'b0);

    // R3 largest forward, R6 most negative offset
    step("R3 max fwd", 32'h1000_7FFF, 32'd9, 32'd9, 32'h0002_0000, 1'b1);
    step("R6 min back", 32'h1400_8000, 32'd1, 32'd0, 32'h0000_0004, 1'b1);

    // R1 reset mid-run with enable low
    en = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again", pc, 32'h0040_0000);
    rst = 1'b0; en = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule